// File: doc/BRIEF.md
# XOR-Matrix Random Bit Generator

This block produces six uniformly distributed random bits on every enabled clock. Its six-bit state sits in flip-flops. On each step, every state bit is replaced by the exclusive-or of two or three bits of the current state. The choice of bits comes from a fixed sparse matrix. No next-state bit needs more than a three-input XOR, so the whole update is one level of logic in front of the registers. All bits change together on one clock edge.

The output is the state word itself. The matrix is chosen so that any non-zero starting value cycles through all 63 non-zero six-bit patterns before it repeats. Zero would map onto itself and stick there forever, so zero is never allowed into the state. Reset puts in a fixed non-zero value, and a seed request carrying zero is replaced by that same value.

A user seeds the generator through the load strobe, which wins over stepping. The user then raises the step enable whenever a fresh sample is wanted. With both controls low, the state holds.

Top module: `xor_matrix_rng`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) makes rnd_out equal 6'b000001 after that edge.
- R2: With step_en high and seed_load low, the next state is computed from the current state s (index 0..5) as n[0]=s[1]^s[2], n[1]=s[1]^s[2]^s[5], n[2]=s[1]^s[3], n[3]=s[0]^s[4], n[4]=s[0]^s[5], n[5]=s[0]^s[3]^s[4].
- R3: With seed_load high and seed_in non-zero, the state becomes seed_in at the next edge, whatever step_en is.
- R4: With seed_load high and seed_in equal to zero, the state becomes 6'b000001 at the next edge.
- R5: With step_en and seed_load both low, the state keeps its value.
- R6: Starting from any non-zero seed, 63 steps bring the state back to the seed, and the 63 states visited are all distinct and non-zero.
- R7: After reset, rnd_out is never zero.
- R8: rnd_out is the register state bit for bit, and it changes only at the edge that takes in the request, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the state by one step |
| seed_load | input | 1 | Load seed_in, priority over step_en |
| seed_in | input | 6 | Seed value; zero is replaced by the default seed |
| rnd_out | output | 6 | Current state, used as the random sample |

## Verification
The assertions rely on reset being applied before the first checked cycle, and on every control input being a known 0 or 1 at each rising edge. The bench meets this by holding reset for the first edge. It changes inputs only on falling edges, and every random draw sets all three controls and the full seed to defined values. The random mix includes cycles where the load and the step are raised together, as well as all-zero seeds, so the priority rule and the zero-seed rule are both exercised.

// File: rtl/xor_matrix_rng.sv
module xor_matrix_rng #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] DFLT_SEED = 6'b000001,
  parameter logic [W*W-1:0] TAPS = {
    6'b011001,
    6'b100001,
    6'b010001,
    6'b001010,
    6'b100110,
    6'b000110
  }
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         seed_load,
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] rnd_out
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_nxt;
  logic [W-1:0] seed_fix;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_row
      assign st_nxt[gi] = ^(st_q & TAPS[gi*W +: W]);
    end
  endgenerate

  assign seed_fix = (seed_in == '0) ? DFLT_SEED : seed_in;

  always_ff @(posedge clk) begin
    if (rst)            st_q <= DFLT_SEED;
    else if (seed_load) st_q <= seed_fix;
    else if (step_en)   st_q <= st_nxt;
  end

  assign rnd_out = st_q;

  a_r1_reset_seed: assert property (@(posedge clk)
    rst |=> rnd_out == DFLT_SEED);

  a_r2_step_bit0: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load) |=> rnd_out[0] == ($past(rnd_out[1]) ^ $past(rnd_out[2])));

  a_r2_step_bit5: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load) |=> rnd_out[5] == ($past(rnd_out[0]) ^ $past(rnd_out[3]) ^ $past(rnd_out[4])));

  a_r3_load_seed: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_in != '0) |=> rnd_out == $past(seed_in));

  a_r4_zero_seed: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_in == '0) |=> rnd_out == DFLT_SEED);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_load) |=> $stable(rnd_out));

  a_r7_never_zero: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rnd_out != '0);

endmodule

// File: tb/xor_matrix_rng_tb.sv
module xor_matrix_rng_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       seed_load = 1'b0;
  logic [5:0] seed_in = '0;
  logic [5:0] rnd_out;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_st = 6'b000001;

  always #5 clk = ~clk;

  xor_matrix_rng u_dut (
    .clk(clk), .rst(rst), .step_en(step_en),
    .seed_load(seed_load), .seed_in(seed_in), .rnd_out(rnd_out)
  );

  function automatic logic [5:0] model_step(input logic [5:0] s);
    logic b1, b2, b3, b4, b5, b6;
    {b6, b5, b4, b3, b2, b1} = s;
    return {b1 ^ b4 ^ b5, b1 ^ b6, b1 ^ b5, b2 ^ b4, b2 ^ b3 ^ b6, b2 ^ b3};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic en, input logic ld, input logic [5:0] sd);
    @(negedge clk);
    rst = r; step_en = en; seed_load = ld; seed_in = sd;
    @(posedge clk);
    #1;
    if (r)       exp_st = 6'b000001;
    else if (ld) exp_st = (sd == 6'd0) ? 6'b000001 : sd;
    else if (en) exp_st = model_step(exp_st);
  endtask

  task automatic period_test(input logic [5:0] seed);
    logic [63:0] seen;
    cycle(1'b0, 1'b0, 1'b1, seed);
    check("R3", rnd_out, seed);
    seen = '0;
    for (int k = 0; k < 63; k++) begin
      checks++;
      if (seen[rnd_out] || rnd_out == 6'd0) begin
        errors++;
        $display("FAIL R6: state %b repeated or zero at step %0d, expected new non-zero", rnd_out, k);
      end
      seen[rnd_out] = 1'b1;
      cycle(1'b0, 1'b1, 1'b0, 6'd0);
      check("R2", rnd_out, exp_st);
    end
    check("R6", rnd_out, seed);
  endtask

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [5:0] held;
    rv = $urandom(32'd2024);
    cycle(1'b1, 1'b1, 1'b1, 6'h2A);
    check("R1", rnd_out, 6'b000001);

    cycle(1'b0, 1'b0, 1'b0, 6'h15);
    check("R5", rnd_out, 6'b000001);

    cycle(1'b0, 1'b1, 1'b0, 6'h00);
    check("R2", rnd_out, model_step(6'b000001));

    held = rnd_out;
    @(negedge clk);
    check("R8", rnd_out, held);

    cycle(1'b0, 1'b1, 1'b1, 6'h2D);
    check("R3", rnd_out, 6'h2D);

    cycle(1'b0, 1'b1, 1'b1, 6'h00);
    check("R4", rnd_out, 6'b000001);

    cycle(1'b0, 1'b0, 1'b1, 6'h00);
    check("R4", rnd_out, 6'b000001);

    period_test(6'h01);
    period_test(6'h2A);
    period_test(6'h3F);
    period_test(6'h20);

    cycle(1'b0, 1'b1, 1'b0, 6'h00);
    cycle(1'b1, 1'b0, 1'b0, 6'h00);
    check("R1", rnd_out, 6'b000001);

    for (int i = 0; i < 3000; i++) begin
      rv = $urandom;
      cycle(rv[31:28] == 4'h0, rv[0] | rv[1], rv[4:2] == 3'b000, rv[5] ? rv[13:8] : 6'd0);
      check("R8", rnd_out, exp_st);
      checks++;
      if (rnd_out == 6'd0) begin
        errors++;
        $display("FAIL R7: actual %b expected non-zero", rnd_out);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule